// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block produces the multiplexer channel address for an eight-input ADC and moves it forward on each conversion strobe. A host programs a channel number, a scan-enable bit and a direction bit through one configuration strobe. It programs a separate interval count through a second strobe. The block has three modes, chosen by the configuration. In single mode every conversion uses the programmed channel. In up-scan mode the address counts from channel 0 up to the programmed channel. In down-scan mode it counts from the programmed channel down to channel 0.

For each conversion the block reports two things: whether that conversion opens a group (first marker) and whether it closes one (end-of-scan). In the scan modes a group is one pass over the channel range. In single mode a group is a burst whose length is the interval count, so single-channel conversions can be paced in bursts. To make scanning hard to turn on by accident, scanning starts only after a configuration write with scanning off has come first. A synchronous clear restarts the current sequence without changing the configuration.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `chan` is 0, `eos` and `first_conv` are 0, the block is in single mode and the interval count is 0.
- R2: In single mode, every conversion strobe leaves `chan` at the programmed channel.
- R3: A configuration write with `cfg_scan_en`=1 turns scanning on only if the previous configuration write had `cfg_scan_en`=0, or if scanning is already on. Otherwise the block stays in single mode on `cfg_chan`. Any write with `cfg_scan_en`=0 turns scanning off.
- R4: Up-scan (`cfg_dir_up`=1) starts at channel 0 and steps +1 per strobe up to the programmed channel, then returns to 0. `first_conv` marks the conversion on channel 0 and `eos` marks the one on the programmed channel.
- R5: Down-scan (`cfg_dir_up`=0) starts at the programmed channel and steps -1 per strobe down to channel 0, then returns to the programmed channel. `first_conv` marks the conversion on the programmed channel and `eos` marks the one on channel 0.
- R6: In single mode with interval count N≥1, `eos` marks every Nth conversion and `first_conv` marks the conversion that opens each burst of N. A count of 0 behaves like 1. The count is 8 bits wide, so 255 is the maximum.
- R7: `ivl_wr` loads `ivl_count` and restarts the burst position. A conversion strobe in the same cycle is ignored.
- R8: `clr` returns `chan` to the start channel of the current mode and restarts the burst position. A conversion strobe in the same cycle is ignored: the channel does not advance and neither `eos` nor `first_conv` is raised.
- R9: `chan` changes only on a clock edge that carries an accepted strobe, a configuration write or a clear. Without these it holds.
- R10: `eos` and `first_conv` are single-cycle pulses in the cycle after the accepted strobe. They describe the channel that was on `chan` when the strobe was taken, and they appear on no other cycle.
- R11: A configuration write puts `chan` at the new mode's start channel and restarts the burst position. A strobe in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous sequence restart |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_chan | input | 3 | Programmed channel (single channel, or end/start of scan) |
| cfg_scan_en | input | 1 | Scan enable request |
| cfg_dir_up | input | 1 | 1 = up-scan, 0 = down-scan |
| ivl_wr | input | 1 | Interval count write strobe |
| ivl_count | input | 8 | Conversions per burst in single mode |
| conv_strobe | input | 1 | Conversion strobe |
| chan | output | 3 | Current multiplexer channel address |
| eos | output | 1 | End-of-scan / end-of-burst pulse |
| first_conv | output | 1 | First conversion of a scan or burst |

## Verification
A conversion strobe can arrive in the same cycle as a clear, an interval-count write or a configuration write. These are the cases where two functions compete for the channel register and the burst counter. The bench walks a scan partway and then raises each of these inputs together with `conv_strobe` on the same edge. In every case the restart must win: `chan` goes to the start channel, and neither `eos` nor `first_conv` pulses in the following cycle. A normal strobe afterwards must report the start channel as the opening conversion.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;
  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_UP   = 2'd1,
    MODE_DOWN = 2'd2
  } seq_mode_e;
endpackage

// File: rtl/scanseq_cfg.sv
module scanseq_cfg
  import scanseq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             cfg_scan,
  input  logic             cfg_up,
  input  logic             ivl_wr,
  input  logic [CNT_W-1:0] ivl_val,
  output seq_mode_e        mode_q,
  output logic [CH_W-1:0]  start_q,
  output logic [CH_W-1:0]  start_d,
  output logic [CH_W-1:0]  end_q,
  output logic [CNT_W-1:0] ivl_q
);
  logic            armed_q, active_q, up_q;
  logic            active_d, up_d;
  logic [CH_W-1:0] last_q, last_d;
  seq_mode_e       mode_d;

  always_comb begin
    active_d = active_q;
    up_d     = up_q;
    last_d   = last_q;
    if (cfg_wr) begin
      active_d = cfg_scan & (armed_q | active_q);
      up_d     = cfg_up;
      last_d   = cfg_chan;
    end
    if (!active_d)  mode_d = MODE_ONE;
    else if (up_d)  mode_d = MODE_UP;
    else            mode_d = MODE_DOWN;
    start_d = (mode_d == MODE_UP) ? '0 : last_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      up_q     <= 1'b0;
      last_q   <= '0;
      mode_q   <= MODE_ONE;
      ivl_q    <= '0;
    end else begin
      if (cfg_wr) armed_q <= ~cfg_scan;
      active_q <= active_d;
      up_q     <= up_d;
      last_q   <= last_d;
      mode_q   <= mode_d;
      if (ivl_wr) ivl_q <= ivl_val;
    end
  end

  assign start_q = (mode_q == MODE_UP) ? '0 : last_q;
  assign end_q   = (mode_q == MODE_DOWN) ? '0 : last_q;

  AST_SCAN_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> $past(armed_q) && $past(cfg_wr)); // R3
  AST_SCAN_OFF_ON_CLEAR_BIT: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_scan) |=> (mode_q == MODE_ONE)); // R3
endmodule

// File: rtl/scanseq_ivl.sv
module scanseq_ivl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero,
  input  logic             step,
  input  logic [CNT_W-1:0] ivl_q,
  output logic             done,
  output logic             at_first
);
  logic [CNT_W-1:0] pos_q;

  assign done     = (ivl_q == '0) || (pos_q == ivl_q - 1'b1);
  assign at_first = (pos_q == '0);

  always_ff @(posedge clk) begin
    if (rst || zero)  pos_q <= '0;
    else if (step)    pos_q <= done ? '0 : pos_q + 1'b1;
  end

  AST_POS_BELOW_COUNT: assert property (@(posedge clk) disable iff (rst)
    (ivl_q != '0) |-> (pos_q < ivl_q)); // R6
  AST_ZERO_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    zero |=> (pos_q == '0)); // R7
endmodule

// File: rtl/scanseq_step.sv
module scanseq_step
  import scanseq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CH_W-1:0] load_val,
  input  logic            clr,
  input  logic            adv,
  input  seq_mode_e       mode_q,
  input  logic [CH_W-1:0] start_q,
  input  logic [CH_W-1:0] end_q,
  input  logic            ivl_done,
  input  logic            ivl_first,
  output logic [CH_W-1:0] chan_q,
  output logic            eos_q,
  output logic            first_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q  <= '0;
      eos_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      eos_q   <= 1'b0;
      first_q <= 1'b0;
      if (load) begin
        chan_q <= load_val;
      end else if (clr) begin
        chan_q <= start_q;
      end else if (adv) begin
        case (mode_q)
          MODE_UP: begin
            first_q <= (chan_q == start_q);
            eos_q   <= (chan_q == end_q);
            chan_q  <= (chan_q == end_q) ? start_q : chan_q + 1'b1;
          end
          MODE_DOWN: begin
            first_q <= (chan_q == start_q);
            eos_q   <= (chan_q == end_q);
            chan_q  <= (chan_q == end_q) ? start_q : chan_q - 1'b1;
          end
          default: begin
            first_q <= ivl_first;
            eos_q   <= ivl_done;
          end
        endcase
      end
    end
  end

  AST_CHAN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load && !clr) |=> $stable(chan_q)); // R9
  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (eos_q || first_q) |-> $past(adv) && !$past(load) && !$past(clr)); // R10
  AST_SINGLE_FIXED: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && !clr && mode_q == MODE_ONE) |=> $stable(chan_q)); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && !clr && mode_q == MODE_DOWN && chan_q != '0)
      |=> (chan_q == CH_W'($past(chan_q) - 1'b1))); // R5
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import scanseq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cfg_wr,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             cfg_scan_en,
  input  logic             cfg_dir_up,
  input  logic             ivl_wr,
  input  logic [CNT_W-1:0] ivl_count,
  input  logic             conv_strobe,
  output logic [CH_W-1:0]  chan,
  output logic             eos,
  output logic             first_conv
);
  seq_mode_e        mode_q;
  logic [CH_W-1:0]  start_q, start_d, end_q;
  logic [CNT_W-1:0] ivl_q;
  logic             adv, ivl_done, ivl_first;

  assign adv = conv_strobe & ~(clr | cfg_wr | ivl_wr);

  scanseq_cfg #(.CH_W(CH_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan),
    .cfg_scan(cfg_scan_en), .cfg_up(cfg_dir_up), .ivl_wr(ivl_wr),
    .ivl_val(ivl_count), .mode_q(mode_q), .start_q(start_q),
    .start_d(start_d), .end_q(end_q), .ivl_q(ivl_q)
  );

  scanseq_ivl #(.CNT_W(CNT_W)) u_ivl (
    .clk(clk), .rst(rst), .zero(clr | cfg_wr | ivl_wr),
    .step(adv && mode_q == MODE_ONE), .ivl_q(ivl_q),
    .done(ivl_done), .at_first(ivl_first)
  );

  scanseq_step #(.CH_W(CH_W)) u_step (
    .clk(clk), .rst(rst), .load(cfg_wr), .load_val(start_d), .clr(clr),
    .adv(adv), .mode_q(mode_q), .start_q(start_q), .end_q(end_q),
    .ivl_done(ivl_done), .ivl_first(ivl_first),
    .chan_q(chan), .eos_q(eos), .first_q(first_conv)
  );

  AST_CLEAR_TO_START: assert property (@(posedge clk) disable iff (rst)
    (clr && !cfg_wr) |=> (chan == $past(start_q)) && !eos && !first_conv); // R8
  AST_CFG_TO_START: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !eos && !first_conv); // R11
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  logic       clk = 1'b0;
  logic       rst, clr, cfg_wr, cfg_scan_en, cfg_dir_up, ivl_wr, conv_strobe;
  logic [2:0] cfg_chan;
  logic [7:0] ivl_count;
  logic [2:0] chan;
  logic       eos, first_conv;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst(rst), .clr(clr), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan),
    .cfg_scan_en(cfg_scan_en), .cfg_dir_up(cfg_dir_up), .ivl_wr(ivl_wr),
    .ivl_count(ivl_count), .conv_strobe(conv_strobe),
    .chan(chan), .eos(eos), .first_conv(first_conv)
  );

  // op: 0 conversion, 1 config write (arg[4]=scan, arg[3]=up, arg[2:0]=chan),
  //     2 interval write, 3 clear
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] arg;
    logic [2:0] ch;
    logic       e;
    logic       f;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h05, 3'd5, 1'b0, 1'b0, 4'd2},  // R2 single on 5
    '{2'd0, 8'h00, 3'd5, 1'b1, 1'b1, 4'd6},  // R6 count 0 acts as 1
    '{2'd1, 8'h1B, 3'd0, 1'b0, 1'b0, 4'd4},  // R4 up to 3, armed
    '{2'd0, 8'h00, 3'd1, 1'b0, 1'b1, 4'd4},
    '{2'd0, 8'h00, 3'd2, 1'b0, 1'b0, 4'd4},
    '{2'd0, 8'h00, 3'd3, 1'b0, 1'b0, 4'd4},
    '{2'd0, 8'h00, 3'd0, 1'b1, 1'b0, 4'd4},  // R4 wrap, eos on 3
    '{2'd0, 8'h00, 3'd1, 1'b0, 1'b1, 4'd4},
    '{2'd3, 8'h00, 3'd0, 1'b0, 1'b0, 4'd8},  // R8 clear
    '{2'd0, 8'h00, 3'd1, 1'b0, 1'b1, 4'd8},
    '{2'd1, 8'h12, 3'd2, 1'b0, 1'b0, 4'd5},  // R5 down from 2
    '{2'd0, 8'h00, 3'd1, 1'b0, 1'b1, 4'd5},
    '{2'd0, 8'h00, 3'd0, 1'b0, 1'b0, 4'd5},
    '{2'd0, 8'h00, 3'd2, 1'b1, 1'b0, 4'd5},  // R5 eos on 0, wrap
    '{2'd1, 8'h06, 3'd6, 1'b0, 1'b0, 4'd3},  // R3 scan off
    '{2'd2, 8'h03, 3'd6, 1'b0, 1'b0, 4'd7},  // R7 burst of 3
    '{2'd0, 8'h00, 3'd6, 1'b0, 1'b1, 4'd6},
    '{2'd0, 8'h00, 3'd6, 1'b0, 1'b0, 4'd6},
    '{2'd0, 8'h00, 3'd6, 1'b1, 1'b0, 4'd6},
    '{2'd0, 8'h00, 3'd6, 1'b0, 1'b1, 4'd6},
    '{2'd2, 8'h01, 3'd6, 1'b0, 1'b0, 4'd7},
    '{2'd0, 8'h00, 3'd6, 1'b1, 1'b1, 4'd6},
    '{2'd1, 8'h18, 3'd0, 1'b0, 1'b0, 4'd4},  // R4 up with last 0
    '{2'd0, 8'h00, 3'd0, 1'b1, 1'b1, 4'd4}
  };

  task automatic check(input int rq, input logic [2:0] ech, input logic ee, input logic ef);
    checks++;
    if (chan !== ech || eos !== ee || first_conv !== ef) begin
      errors++;
      $display("FAIL R%0d: chan/eos/first = %0d/%0b/%0b, expected %0d/%0b/%0b",
               rq, chan, eos, first_conv, ech, ee, ef);
    end
  endtask

  // Drive the selected strobes for one clock, then sample at the next falling edge.
  task automatic pulse(input bit c, input bit w, input bit iw, input bit s);
    @(negedge clk);
    clr = c; cfg_wr = w; ivl_wr = iw; conv_strobe = s;
    @(negedge clk);
    clr = 0; cfg_wr = 0; ivl_wr = 0; conv_strobe = 0;
  endtask

  task automatic set_cfg(input logic [7:0] a);
    cfg_scan_en = a[4]; cfg_dir_up = a[3]; cfg_chan = a[2:0];
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  initial begin
    rst = 1; clr = 0; cfg_wr = 0; ivl_wr = 0; conv_strobe = 0;
    cfg_chan = 0; cfg_scan_en = 0; cfg_dir_up = 0; ivl_count = 0;
    do_reset();
    check(1, 3'd0, 1'b0, 1'b0); // R1 reset state

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: pulse(0, 0, 0, 1);
        2'd1: begin set_cfg(VECS[i].arg); pulse(0, 1, 0, 0); end
        2'd2: begin ivl_count = VECS[i].arg; pulse(0, 0, 1, 0); end
        default: pulse(1, 0, 0, 0);
      endcase
      check(int'(VECS[i].rq), VECS[i].ch, VECS[i].e, VECS[i].f);
    end

    // R3: scan request straight after reset is not armed -> single on 3
    do_reset();
    set_cfg(8'h1B); pulse(0, 1, 0, 0);
    check(3, 3'd3, 1'b0, 1'b0);
    pulse(0, 0, 0, 1);
    check(3, 3'd3, 1'b1, 1'b1);

    // Arm, then up-scan to 5 and walk to channel 2
    set_cfg(8'h05); pulse(0, 1, 0, 0);
    set_cfg(8'h1D); pulse(0, 1, 0, 0);
    pulse(0, 0, 0, 1); pulse(0, 0, 0, 1);
    check(4, 3'd2, 1'b0, 1'b0);

    // R9: idle cycles, channel holds and no pulses
    repeat (4) @(negedge clk);
    check(9, 3'd2, 1'b0, 1'b0);

    // R8: clear and strobe together, clear wins
    pulse(1, 0, 0, 1);
    check(8, 3'd0, 1'b0, 1'b0);
    pulse(0, 0, 0, 1); pulse(0, 0, 0, 1);
    check(10, 3'd2, 1'b0, 1'b0);

    // R7: interval write and strobe together, strobe ignored
    ivl_count = 8'd2;
    pulse(0, 0, 1, 1);
    check(7, 3'd2, 1'b0, 1'b0);

    // R11: config write and strobe together, down-scan from 4
    set_cfg(8'h14);
    pulse(0, 1, 0, 1);
    check(11, 3'd4, 1'b0, 1'b0);
    pulse(0, 0, 0, 1);
    check(10, 3'd3, 1'b0, 1'b1);
    @(negedge clk);
    check(10, 3'd3, 1'b0, 1'b0); // R10 pulse lasts one cycle

    // R6: burst of 2 in single mode; pulses repeat back-to-back
    set_cfg(8'h07); pulse(0, 1, 0, 0);
    pulse(0, 0, 0, 1); check(6, 3'd7, 1'b0, 1'b1);
    pulse(0, 0, 0, 1); check(6, 3'd7, 1'b1, 1'b0);
    pulse(0, 0, 0, 1); check(6, 3'd7, 1'b0, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule